// File: doc/BRIEF.md
# EDO DRAM Access Cycle Classifier

This block observes the active-low control strobes of a two-byte-lane EDO DRAM port (row strobe, one column strobe per byte lane, write enable and output enable). It labels every memory access with its cycle type: read, early write, delayed write, read-modify-write, CAS-before-RAS refresh or RAS-only refresh. The strobes are treated as asynchronous. They pass through multi-flop synchronizers, and every ordering decision is made on the synchronized samples.

An access starts when the row strobe becomes active and ends when it returns inactive. The lane column strobes are combined by OR. The column access opens when the first lane strobe goes active and closes when the last one goes inactive. Lane selection and per-lane output state are still tracked one lane at a time. Only the first column access inside a row access is classified. When the row strobe goes inactive, the block presents a one-cycle report. The report holds a cycle code, a lane mask and a per-lane output-state field. Its intended uses are protocol monitoring and bus trace decoding.

Top module: `dram_cyc_decode`

## Requirements
- R1: While the row strobe is inactive, no activity on the other strobes produces a report, and the outputs stay at standby: acc_kind 0, acc_lanes 0, acc_drive 0 (all lanes high-impedance).
- R2: acc_lanes bit 0 is the lower lane and bit 1 is the upper lane. A bit is set when that lane strobe was active during the first column access. A lane whose bit is clear always reports high-impedance.
- R3: The column access opens on the first lane strobe to go active and closes on the last one to go inactive. Staggered lane strobes therefore form one access with both lanes selected. A later column access in the same row access does not change the result.
- R4: A column access with write enable never active is a read, code 1. Each selected lane reports valid (01) if output enable was active during the access, and high-impedance (00) if it was not.
- R5: Write enable active in or before the sample where the column access opens gives an early write, code 2, with every lane high-impedance.
- R6: Write enable going active after the column access opened, with output enable not active before it, gives a delayed write, code 3. Each selected lane reports undefined (10).
- R7: Output enable active, then write enable going active later in the same column access, gives a read-modify-write, code 4. Each selected lane reports valid.
- R8: Any lane strobe active in the sample where the row strobe goes active gives a CAS-before-RAS refresh, code 5, with lane mask 0 and all lanes high-impedance. This also applies when only one lane strobe is low.
- R9: A row access with no lane strobe ever active gives a RAS-only refresh, code 6, with lane mask 0 and all lanes high-impedance.
- R10: Each row access produces exactly one report. acc_vld is high for one cycle, within 12 clocks after the row strobe returns inactive, and the fields return to standby values in the next cycle.
- R11: A synchronous active-low reset forces standby outputs with acc_vld low and discards any access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| row_n | input | 1 | Row strobe, active low, asynchronous |
| col_n | input | LANES (2) | Lane column strobes, active low; bit 0 lower, bit 1 upper |
| wen_n | input | 1 | Write enable, active low |
| oen_n | input | 1 | Output enable, active low |
| acc_vld | output | 1 | One-cycle report strobe |
| acc_kind | output | 3 | Cycle code (0 standby to 6 RAS-only refresh) |
| acc_lanes | output | LANES (2) | Lanes selected by the access |
| acc_drive | output | 2*LANES (4) | Per-lane output state: 00 high-Z, 01 valid, 10 undefined; bits [1:0] lower |

## Verification
The bench aims at the orderings that separate cycle types. Write enable falling in the same sample as the column strobe must give an early write; a design that requires strict precedence reports it as delayed. Lane strobes that fall and rise at different times must form one word access; a design that closes the access on the first rising lane drops the upper lane or opens a second access. A refresh with only the upper lane strobe low must still be CAS-before-RAS; a design that ANDs the lane strobes reports a read or a RAS-only refresh. A write inside a second column access after the first one closed must not turn a read into a write. Random accesses of every type and lane mix check the read-modify-write versus delayed-write split. They also check that no report appears while the row strobe is idle.

// File: rtl/dram_cyc_pkg.sv
// Package: shared cycle codes and lane output states for the EDO cycle classifier.
// Assumes: the code values are part of the external report format.
package dram_cyc_pkg;
    typedef enum logic [2:0] {
        CYC_IDLE = 3'd0,
        CYC_READ = 3'd1,
        CYC_EWR  = 3'd2,
        CYC_DWR  = 3'd3,
        CYC_RMW  = 3'd4,
        CYC_CBR  = 3'd5,
        CYC_ROR  = 3'd6
    } cyc_kind_t;

    typedef enum logic [1:0] {
        LN_HIZ   = 2'd0,
        LN_VALID = 2'd1,
        LN_UNDEF = 2'd2
    } ln_state_t;
endpackage

// File: rtl/dram_cyc_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous active-low strobes.
// Assumes: each bit is independent, and reset loads the inactive (high) level.
module dram_cyc_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the strobe sample one stage deeper each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '1;
                else if (s == 0) stg[s] <= d;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dram_cyc_track.sv
// Module: follows one row access on synchronized active-high strobes and records
// the ordering facts that decide the cycle type.
// Assumes: only the first column access in a row access is classified, and events
// in the same sample count as simultaneous.
module dram_cyc_track #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras,
    input  logic [LANES-1:0] cas,
    input  logic             we,
    input  logic             oe,
    output logic             done,
    output logic             cbr,
    output logic [LANES-1:0] mask,
    output logic             we_early,
    output logic             we_late,
    output logic             oe_read
);
    logic ras_q, in_acc, col_open, col_done;
    logic cas_any;

    assign cas_any = |cas;
    assign done    = in_acc && ras_q && !ras;

    // Start an access on row-strobe assertion, then record the first column access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q    <= 1'b0;
            in_acc   <= 1'b0;
            cbr      <= 1'b0;
            col_open <= 1'b0;
            col_done <= 1'b0;
            mask     <= '0;
            we_early <= 1'b0;
            we_late  <= 1'b0;
            oe_read  <= 1'b0;
        end else begin
            ras_q <= ras;
            if (ras && !ras_q) begin
                in_acc   <= 1'b1;
                cbr      <= cas_any;
                col_open <= 1'b0;
                col_done <= 1'b0;
                mask     <= '0;
                we_early <= 1'b0;
                we_late  <= 1'b0;
                oe_read  <= 1'b0;
            end else if (!ras) begin
                in_acc   <= 1'b0;
                col_open <= 1'b0;
            end else if (in_acc && !cbr && !col_done) begin
                if (cas_any) begin
                    col_open <= 1'b1;
                    mask     <= mask | cas;
                    if (!col_open) begin
                        if (we) we_early <= 1'b1;
                        else if (oe) oe_read <= 1'b1;
                    end else begin
                        if (we && !we_early && !we_late) we_late <= 1'b1;
                        if (oe && !we && !we_early && !we_late) oe_read <= 1'b1;
                    end
                end else if (col_open) begin
                    col_open <= 1'b0;
                    col_done <= 1'b1;
                end
            end
        end
    end

    // R2: an open column access always has at least one lane recorded.
    p_mask_on_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        col_open |-> (mask != '0));

    // R8: a refresh started with a lane strobe low never opens a column access.
    p_cbr_no_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_acc && cbr) |-> !col_open);

    // R5: early and late write are mutually exclusive.
    p_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_early && we_late));
endmodule

// File: rtl/dram_cyc_classify.sv
// Module: maps the recorded ordering facts of one access to a cycle code, a lane mask
// and a per-lane output state.
// Assumes: the inputs are stable in the cycle where the tracker flags completion.
module dram_cyc_classify
    import dram_cyc_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic               cbr,
    input  logic [LANES-1:0]   mask,
    input  logic               we_early,
    input  logic               we_late,
    input  logic               oe_read,
    output cyc_kind_t          kind,
    output logic [LANES-1:0]   lanes,
    output logic [2*LANES-1:0] drive
);
    // Pick the cycle code by precedence: refresh first, then write timing, then read.
    always_comb begin
        if (cbr)                kind = CYC_CBR;
        else if (mask == '0)    kind = CYC_ROR;
        else if (we_early)      kind = CYC_EWR;
        else if (we_late)       kind = oe_read ? CYC_RMW : CYC_DWR;
        else                    kind = CYC_READ;
    end

    // Report lanes only for column accesses.
    always_comb begin
        lanes = (kind == CYC_CBR || kind == CYC_ROR) ? '0 : mask;
    end

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            ln_state_t st;
            // Derive one lane's output state from its selection and the cycle code.
            always_comb begin
                st = LN_HIZ;
                if (lanes[i]) begin
                    case (kind)
                        CYC_READ, CYC_RMW: st = oe_read ? LN_VALID : LN_HIZ;
                        CYC_DWR:           st = LN_UNDEF;
                        default:           st = LN_HIZ;
                    endcase
                end
            end
            assign drive[2*i +: 2] = st;

            // R2: an unselected lane never reports a driven or undefined output.
            always_comb begin
                if (!lanes[i]) p_unsel_lane_r2: assert (drive[2*i +: 2] == LN_HIZ);
            end
        end
    endgenerate
endmodule

// File: rtl/dram_cyc_decode.sv
// Module: top of the EDO cycle classifier. Synchronizes the strobes, tracks each row
// access and registers a one-cycle report when the row strobe goes inactive.
// Assumes: the strobes are asynchronous and active low; reset is synchronous, active low.
module dram_cyc_decode
    import dram_cyc_pkg::*;
#(
    parameter int LANES       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               row_n,
    input  logic [LANES-1:0]   col_n,
    input  logic               wen_n,
    input  logic               oen_n,
    output logic               acc_vld,
    output logic [2:0]         acc_kind,
    output logic [LANES-1:0]   acc_lanes,
    output logic [2*LANES-1:0] acc_drive
);
    localparam int SW = LANES + 3;

    logic [SW-1:0]      raw, syn;
    logic               ras, we, oe;
    logic [LANES-1:0]   cas;
    logic               done, cbr, we_early, we_late, oe_read;
    logic [LANES-1:0]   mask, lanes;
    logic [2*LANES-1:0] drive;
    cyc_kind_t          kind;

    assign raw = {oen_n, wen_n, col_n, row_n};

    dram_cyc_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign ras = ~syn[0];
    assign cas = ~syn[LANES:1];
    assign we  = ~syn[LANES+1];
    assign oe  = ~syn[LANES+2];

    dram_cyc_track #(.LANES(LANES)) u_track (
        .clk(clk), .rst_n(rst_n), .ras(ras), .cas(cas), .we(we), .oe(oe),
        .done(done), .cbr(cbr), .mask(mask), .we_early(we_early),
        .we_late(we_late), .oe_read(oe_read)
    );

    dram_cyc_classify #(.LANES(LANES)) u_class (
        .cbr(cbr), .mask(mask), .we_early(we_early), .we_late(we_late),
        .oe_read(oe_read), .kind(kind), .lanes(lanes), .drive(drive)
    );

    // Register the report for one cycle on access completion, standby otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_vld   <= 1'b0;
            acc_kind  <= CYC_IDLE;
            acc_lanes <= '0;
            acc_drive <= '0;
        end else if (done) begin
            acc_vld   <= 1'b1;
            acc_kind  <= kind;
            acc_lanes <= lanes;
            acc_drive <= drive;
        end else begin
            acc_vld   <= 1'b0;
            acc_kind  <= CYC_IDLE;
            acc_lanes <= '0;
            acc_drive <= '0;
        end
    end

    // R10: the report strobe never lasts two cycles.
    p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |=> !acc_vld);

    // R5: early writes and both refresh types leave every lane high-impedance.
    p_quiet_kinds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && (acc_kind == CYC_EWR || acc_kind == CYC_CBR || acc_kind == CYC_ROR))
        |-> (acc_drive == '0));

    // R8: refresh reports carry no lane selection.
    p_ref_nolanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && (acc_kind == CYC_CBR || acc_kind == CYC_ROR)) |-> (acc_lanes == '0));

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_chk
            // R6: a selected lane of a delayed write reports undefined.
            p_dwr_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_vld && acc_kind == CYC_DWR && acc_lanes[i])
                |-> (acc_drive[2*i +: 2] == LN_UNDEF));
            // R2: a lane outside the mask stays high-impedance in the report.
            p_unsel_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !acc_lanes[i] |-> (acc_drive[2*i +: 2] == LN_HIZ));
        end
    endgenerate
endmodule

// File: tb/tb_dram_cyc_decode.sv
module tb_dram_cyc_decode;
    localparam int L = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         row_n = 1'b1;
    logic [L-1:0] col_n = '1;
    logic         wen_n = 1'b1;
    logic         oen_n = 1'b1;
    logic         acc_vld;
    logic [2:0]   acc_kind;
    logic [L-1:0] acc_lanes;
    logic [2*L-1:0] acc_drive;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  stray = 0;
    bit  win = 1'b0;

    always #2 clk = ~clk;

    dram_cyc_decode #(.LANES(L), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
        .wen_n(wen_n), .oen_n(oen_n), .acc_vld(acc_vld), .acc_kind(acc_kind),
        .acc_lanes(acc_lanes), .acc_drive(acc_drive)
    );

    always @(negedge clk) if (rst_n && acc_vld && !win) stray++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drv(logic r, logic [L-1:0] c, logic w, logic o);
        @(negedge clk);
        row_n = r; col_n = c; wen_n = w; oen_n = o;
        repeat (4) @(posedge clk);
    endtask

    // Expected {kind, lanes, drive}: typ 0 read, 1 early wr, 2 delayed wr, 3 rmw, 4 cbr, 5 ras-only
    function automatic logic [8:0] expect_out(int typ, logic [1:0] ln, bit oe_on);
        logic [2:0] k;
        logic [1:0] m;
        logic [1:0] st;
        logic [3:0] d;
        case (typ)
            0: begin k = 3'd1; m = ln; st = oe_on ? 2'b01 : 2'b00; end
            1: begin k = 3'd2; m = ln; st = 2'b00; end
            2: begin k = 3'd3; m = ln; st = 2'b10; end
            3: begin k = 3'd4; m = ln; st = 2'b01; end
            4: begin k = 3'd5; m = 2'b00; st = 2'b00; end
            default: begin k = 3'd6; m = 2'b00; st = 2'b00; end
        endcase
        d = {m[1] ? st : 2'b00, m[0] ? st : 2'b00};
        return {k, m, d};
    endfunction

    task automatic finish_acc(logic [8:0] e, string req);
        bit found = 1'b0;
        @(negedge clk);
        win = 1'b1;
        row_n = 1'b1; col_n = '1; wen_n = 1'b1; oen_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (acc_vld) begin found = 1'b1; break; end
        end
        chk({req, " R10 report seen"}, {31'd0, found}, 32'd1);
        if (found) begin
            chk({req, " kind"}, {29'd0, acc_kind}, {29'd0, e[8:6]});
            chk({req, " lanes R2"}, {30'd0, acc_lanes}, {30'd0, e[5:4]});
            chk({req, " drive"}, {28'd0, acc_drive}, {28'd0, e[3:0]});
            @(negedge clk);
            chk("R10 one-cycle pulse", {31'd0, acc_vld}, 32'd0);
            chk("R10 standby after report", {29'd0, acc_kind}, 32'd0);
        end
        win = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic run_acc(int typ, logic [1:0] ln, bit oe_on);
        logic [1:0] c = ~ln;
        string tag;
        case (typ)
            0: begin tag = "R4 read";
                drv(0, 2'b11, 1, 1); drv(0, c, 1, 1); if (oe_on) drv(0, c, 1, 0); end
            1: begin tag = "R5 early write";
                drv(1, 2'b11, 0, 1); drv(0, 2'b11, 0, 1); drv(0, c, 0, 1); end
            2: begin tag = "R6 delayed write";
                drv(0, 2'b11, 1, 1); drv(0, c, 1, 1); drv(0, c, 0, 1); end
            3: begin tag = "R7 read-modify-write";
                drv(0, 2'b11, 1, 1); drv(0, c, 1, 1); drv(0, c, 1, 0); drv(0, c, 0, 1); end
            4: begin tag = "R8 cbr refresh";
                drv(1, c, 1, 1); drv(0, c, 1, 1); end
            default: begin tag = "R9 ras-only refresh";
                drv(0, 2'b11, 1, 1); end
        endcase
        finish_acc(expect_out(typ, ln, oe_on), tag);
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11 reset vld", {31'd0, acc_vld}, 32'd0);
        chk("R11 reset kind", {29'd0, acc_kind}, 32'd0);
        chk("R11 reset drive hiz", {28'd0, acc_drive}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);

        // R1: activity with the row strobe idle yields nothing
        for (int i = 0; i < 8; i++)
            drv(1, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        drv(1, 2'b11, 1, 1);
        @(negedge clk);
        chk("R1 no report while idle", stray, 0);
        chk("R1 standby kind", {29'd0, acc_kind}, 32'd0);
        chk("R1 standby lanes", {30'd0, acc_lanes}, 32'd0);
        chk("R1 standby drive", {28'd0, acc_drive}, 32'd0);

        // Directed cases per type
        run_acc(0, 2'b01, 1'b1);
        run_acc(0, 2'b11, 1'b0);
        run_acc(1, 2'b10, 1'b0);
        run_acc(2, 2'b11, 1'b0);
        run_acc(3, 2'b01, 1'b1);
        run_acc(4, 2'b10, 1'b0);   // R8: only the upper lane strobe low
        run_acc(5, 2'b00, 1'b0);

        // R3: staggered lanes form one word read; second column access ignored
        drv(0, 2'b11, 1, 1);
        drv(0, 2'b10, 1, 1);
        drv(0, 2'b00, 1, 0);
        drv(0, 2'b01, 1, 0);
        drv(0, 2'b11, 1, 1);
        drv(0, 2'b00, 0, 1);
        finish_acc({3'd1, 2'b11, 4'b0101}, "R3 staggered word read");

        // R5: write enable and column strobe in the same sample count as early
        drv(0, 2'b11, 1, 1);
        drv(0, 2'b00, 0, 1);
        finish_acc({3'd2, 2'b11, 4'b0000}, "R5 simultaneous early write");

        // Random mix
        for (int n = 0; n < 40; n++) begin
            int t = $urandom_range(0, 5);
            logic [1:0] ln = 2'($urandom_range(1, 3));
            bit o = 1'($urandom_range(0, 1));
            run_acc(t, ln, o);
        end

        // R11: reset in mid-access discards it
        drv(0, 2'b11, 1, 1);
        drv(0, 2'b00, 1, 0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset mid-access vld", {31'd0, acc_vld}, 32'd0);
        chk("R11 reset mid-access kind", {29'd0, acc_kind}, 32'd0);
        row_n = 1'b1; col_n = '1; wen_n = 1'b1; oen_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R10 no stray reports", stray, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule